// File: doc/BRIEF.md
# Interrupt Source Capture and Routing Block

This block accepts a bank of raw interrupt lines and turns them into per-destination pending vectors. Every line owns an 8-bit control byte that decides whether it may become pending, how it is detected (high level, rising edge, falling edge or either edge) and which of eight destinations it reaches. Inputs pass through a two-stage synchronizer before detection. Edge events are held in status words until software clears them by writing ones. Level sources show their synchronized input directly in the same status words.

Software reaches the control bytes and the status words through a simple register port: an address, a write strobe, a 32-bit write word and a registered 32-bit read word. Choosing among the pending sources and reporting a vector is done by a separate downstream block that consumes the pending vectors.

Top module: `irq_capture_router`

## Requirements
- R1: After reset every control byte reads 0x00 and no bit of `pend_flat` is set.
- R2: A write to address 0x40+n stores bits 7:0 of the write word as the control byte of source n. A read of that address returns the byte zero-extended, one cycle after the address is presented.
- R3: When bit 3 of a source's control byte is 0, that source is never pending on any destination.
- R4: With control bits 5 and 6 both 0 a source is active-high level sensitive: it is pending while its synchronized input is high and stops when the input goes low. Its status bit reads the synchronized level, and a write of 1 to that status bit has no effect.
- R5: With bit 5 set and bit 6 clear, a 0-to-1 input transition latches the status bit. The bit stays set after the input falls, until it is cleared.
- R6: With bit 6 set and bit 5 clear, only a 1-to-0 transition latches the status bit; a rising transition does not.
- R7: With bits 5 and 6 both set, either transition latches the status bit.
- R8: Status word at 0x80 holds sources 0 to 31 (bit n = source n). The word at 0x84 holds sources 32 to 63 (bit n = source 32+n). Writing 1 to a bit clears a latched edge event; writing 0 leaves it unchanged.
- R9: When a new edge event and a clearing write to the same bit take effect in the same cycle, the bit stays set.
- R10: Bits 2:0 of the control byte give a destination d in 0..7 (0 is the normal interrupt output, 1 the fast interrupt output, 2 to 7 auxiliary outputs). An enabled, set source n appears only at `pend_flat[d*64+n]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Write strobe, one write per cycle |
| reg_wdata | input | 32 | Write word; control bytes take bits 7:0 |
| reg_rdata | output | 32 | Registered read word for the previous cycle's address |
| irq_in | input | 64 | Raw interrupt lines, asynchronous |
| pend_flat | output | 512 | Pending vectors, destination d at bits d*64+63 down to d*64 |

## Verification
The hardest case to reach from the ports is the collision of a clearing write with a fresh edge on the same bit in the same cycle. The input has to cross two synchronizer flops and the edge detector, so the write has to be placed exactly. The stimulus first latches an edge on a source. It then raises the input again and counts clock edges through the synchronizer, asserting the clearing write in the cycle in which the new edge is being registered. It then checks that the source is still pending. A plain clear without a new edge follows, to show that the write does clear the bit.

// File: rtl/irq_cr_pkg.sv
package irq_cr_pkg;
  localparam int CTRL_W        = 8;
  localparam int DEST_W        = 3;
  localparam int CTRL_EN_BIT   = 3;
  localparam int CTRL_RISE_BIT = 5;
  localparam int CTRL_FALL_BIT = 6;
  localparam int WORD_W        = 32;
  localparam int CTRL_BASE     = 'h40;
  localparam int STAT_BASE     = 'h80;

  typedef logic [CTRL_W-1:0] ctrl_byte_t;

  function automatic logic [DEST_W-1:0] ctrl_dest(input ctrl_byte_t c);
    return c[DEST_W-1:0];
  endfunction
endpackage

// File: rtl/irq_cr_sync.sv
module irq_cr_sync #(
  parameter int W      = 64,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
  end

  assign d_out = stg[STAGES-1];
endmodule

// File: rtl/irq_cr_ctrl_bank.sv
module irq_cr_ctrl_bank
  import irq_cr_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int ADDR_W  = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [CTRL_W-1:0]          wbyte,
  output logic [NUM_SRC*CTRL_W-1:0]  ctrl_flat,
  output logic [NUM_SRC-1:0]         en_vec,
  output logic [NUM_SRC-1:0]         rise_vec,
  output logic [NUM_SRC-1:0]         fall_vec,
  output logic [NUM_SRC*DEST_W-1:0]  dest_flat
);
  ctrl_byte_t ctrl_q [NUM_SRC];

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst) ctrl_q[n] <= '0;
      else if (wr && addr == ADDR_W'(CTRL_BASE + n)) ctrl_q[n] <= wbyte;
    end
    assign ctrl_flat[n*CTRL_W +: CTRL_W] = ctrl_q[n];
    assign en_vec[n]   = ctrl_q[n][CTRL_EN_BIT];
    assign rise_vec[n] = ctrl_q[n][CTRL_RISE_BIT];
    assign fall_vec[n] = ctrl_q[n][CTRL_FALL_BIT];
    assign dest_flat[n*DEST_W +: DEST_W] = ctrl_dest(ctrl_q[n]);
  end
endmodule

// File: rtl/irq_cr_detect.sv
module irq_cr_detect #(
  parameter int NUM_SRC = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] sync_in,
  input  logic [NUM_SRC-1:0] rise_vec,
  input  logic [NUM_SRC-1:0] fall_vec,
  input  logic [NUM_SRC-1:0] clr_mask,
  output logic [NUM_SRC-1:0] edge_mask,
  output logic [NUM_SRC-1:0] status
);
  logic [NUM_SRC-1:0] prev_q;
  logic [NUM_SRC-1:0] latch_q;
  logic [NUM_SRC-1:0] evt;

  assign edge_mask = rise_vec | fall_vec;
  assign evt = (sync_in & ~prev_q & rise_vec) | (~sync_in & prev_q & fall_vec);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= '0;
      latch_q <= '0;
    end else begin
      prev_q  <= sync_in;
      // a new event overrides a clear in the same cycle
      latch_q <= edge_mask & (evt | (latch_q & ~clr_mask));
    end
  end

  assign status = (edge_mask & latch_q) | (~edge_mask & sync_in);
endmodule

// File: rtl/irq_cr_route.sv
module irq_cr_route
  import irq_cr_pkg::*;
#(
  parameter int NUM_SRC  = 64,
  parameter int NUM_DEST = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_SRC-1:0]           en_vec,
  input  logic [NUM_SRC-1:0]           status,
  input  logic [NUM_SRC*DEST_W-1:0]    dest_flat,
  output logic [NUM_DEST*NUM_SRC-1:0]  pend_flat
);
  for (genvar d = 0; d < NUM_DEST; d++) begin : g_dest
    for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
      always_ff @(posedge clk) begin
        if (rst) pend_flat[d*NUM_SRC+n] <= 1'b0;
        else pend_flat[d*NUM_SRC+n] <= en_vec[n] & status[n] &
                                       (dest_flat[n*DEST_W +: DEST_W] == DEST_W'(d));
      end
    end
  end
endmodule

// File: rtl/irq_capture_router.sv
module irq_capture_router
  import irq_cr_pkg::*;
#(
  parameter int NUM_SRC     = 64,
  parameter int NUM_DEST    = 8,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [ADDR_W-1:0]            reg_addr,
  input  logic                         reg_wr,
  input  logic [WORD_W-1:0]            reg_wdata,
  output logic [WORD_W-1:0]            reg_rdata,
  input  logic [NUM_SRC-1:0]           irq_in,
  output logic [NUM_DEST*NUM_SRC-1:0]  pend_flat
);
  localparam int N_WORDS = NUM_SRC / WORD_W;

  logic [NUM_SRC*CTRL_W-1:0] ctrl_flat;
  logic [NUM_SRC-1:0]        en_vec, rise_vec, fall_vec;
  logic [NUM_SRC*DEST_W-1:0] dest_flat;
  logic [NUM_SRC-1:0]        sync_vec, edge_mask, status_vec, clr_mask;
  logic [WORD_W-1:0]         rd_next;

  irq_cr_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_in(irq_in), .d_out(sync_vec)
  );

  irq_cr_ctrl_bank #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr),
    .wbyte(reg_wdata[CTRL_W-1:0]), .ctrl_flat(ctrl_flat),
    .en_vec(en_vec), .rise_vec(rise_vec), .fall_vec(fall_vec),
    .dest_flat(dest_flat)
  );

  for (genvar w = 0; w < N_WORDS; w++) begin : g_clr
    assign clr_mask[w*WORD_W +: WORD_W] =
      (reg_wr && reg_addr == ADDR_W'(STAT_BASE + 4*w)) ? reg_wdata : '0;
  end

  irq_cr_detect #(.NUM_SRC(NUM_SRC)) u_det (
    .clk(clk), .rst(rst), .sync_in(sync_vec), .rise_vec(rise_vec),
    .fall_vec(fall_vec), .clr_mask(clr_mask), .edge_mask(edge_mask),
    .status(status_vec)
  );

  irq_cr_route #(.NUM_SRC(NUM_SRC), .NUM_DEST(NUM_DEST)) u_route (
    .clk(clk), .rst(rst), .en_vec(en_vec), .status(status_vec),
    .dest_flat(dest_flat), .pend_flat(pend_flat)
  );

  always_comb begin
    rd_next = '0;
    for (int n = 0; n < NUM_SRC; n++)
      if (reg_addr == ADDR_W'(CTRL_BASE + n))
        rd_next = {{(WORD_W-CTRL_W){1'b0}}, ctrl_flat[n*CTRL_W +: CTRL_W]};
    for (int w = 0; w < N_WORDS; w++)
      if (reg_addr == ADDR_W'(STAT_BASE + 4*w))
        rd_next = status_vec[w*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_next;
  end
endmodule

// File: rtl/irq_cr_checker.sv
module irq_cr_checker #(
  parameter int NUM_SRC  = 64,
  parameter int NUM_DEST = 8
) (
  input logic                        clk,
  input logic                        rst,
  input logic [NUM_SRC-1:0]          en_vec,
  input logic [NUM_SRC-1:0]          edge_mask,
  input logic [NUM_SRC-1:0]          status_vec,
  input logic [NUM_SRC-1:0]          clr_mask,
  input logic [NUM_DEST*NUM_SRC-1:0] pend_flat
);
  logic past_valid, was_rst;
  logic [NUM_SRC-1:0] pend_any;

  always_ff @(posedge clk) begin
    if (rst) past_valid <= 1'b0;
    else     past_valid <= 1'b1;
    was_rst <= rst;
  end

  always_comb begin
    pend_any = '0;
    for (int d = 0; d < NUM_DEST; d++)
      pend_any = pend_any | pend_flat[d*NUM_SRC +: NUM_SRC];
  end

  // R1: nothing pending in the first cycle out of reset
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    was_rst |-> (pend_flat == '0));

  // R3: a source disabled in the previous cycle is not pending now
  a_r3_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    past_valid |-> ((pend_any & ~$past(en_vec)) == '0));

  // R5: a latched edge stays set while still in edge mode and not cleared
  a_r5_edge_sticky: assert property (@(posedge clk) disable iff (rst)
    past_valid |-> (($past(status_vec & edge_mask & ~clr_mask) & edge_mask & ~status_vec) == '0));

  // R10: each source is pending on at most one destination
  for (genvar n = 0; n < NUM_SRC; n++) begin : g_col
    logic [NUM_DEST-1:0] col;
    for (genvar d = 0; d < NUM_DEST; d++) begin : g_bit
      assign col[d] = pend_flat[d*NUM_SRC+n];
    end
    a_r10_single_dest: assert property (@(posedge clk) disable iff (rst)
      $onehot0(col));
  end
endmodule

bind irq_capture_router irq_cr_checker #(.NUM_SRC(NUM_SRC), .NUM_DEST(NUM_DEST)) u_chk (
  .clk(clk), .rst(rst), .en_vec(en_vec), .edge_mask(edge_mask),
  .status_vec(status_vec), .clr_mask(clr_mask), .pend_flat(pend_flat)
);

// File: tb/tb_irq_capture_router.sv
`timescale 1ns/1ps
module tb_irq_capture_router;
  logic         clk = 1'b0;
  logic         rst;
  logic [7:0]   reg_addr;
  logic         reg_wr;
  logic [31:0]  reg_wdata;
  logic [31:0]  reg_rdata;
  logic [63:0]  irq_in;
  logic [511:0] pend_flat;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  irq_capture_router dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_in(irq_in),
    .pend_flat(pend_flat)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  function automatic logic pend_at(input int d, input int n);
    return pend_flat[d*64+n];
  endfunction

  function automatic logic [7:0] pend_col(input int n);
    logic [7:0] c;
    for (int d = 0; d < 8; d++) c[d] = pend_flat[d*64+n];
    return c;
  endfunction

  task automatic t_reset;
    logic [31:0] v;
    rd_reg(8'h40, v); check("R1 ctrl0", v, 32'h0);
    rd_reg(8'h7F, v); check("R1 ctrl63", v, 32'h0);
    check("R1 pend", {31'b0, |pend_flat}, 32'h0);
  endtask

  task automatic t_ctrl_rw;
    logic [31:0] v;
    wr_reg(8'h45, 32'hFFFF_FF91);
    rd_reg(8'h45, v); check("R2 ctrl5 readback", v, 32'h91);
    rd_reg(8'h46, v); check("R2 neighbour untouched", v, 32'h0);
    wr_reg(8'h45, 32'h0);
  endtask

  task automatic t_level;
    logic [31:0] v;
    wr_reg(8'h43, 32'h08);
    irq_in[3] = 1'b1; wait_cyc(6);
    check("R4 level pending", {31'b0, pend_at(0, 3)}, 32'h1);
    rd_reg(8'h80, v); check("R4 status reads level", {31'b0, v[3]}, 32'h1);
    wr_reg(8'h80, 32'h8); wait_cyc(4);
    check("R4 clear ignored", {31'b0, pend_at(0, 3)}, 32'h1);
    irq_in[3] = 1'b0; wait_cyc(6);
    check("R4 level drops", {31'b0, pend_at(0, 3)}, 32'h0);
  endtask

  task automatic t_disable;
    wr_reg(8'h44, 32'h00);
    irq_in[4] = 1'b1; wait_cyc(6);
    check("R3 disabled level", {24'b0, pend_col(4)}, 32'h0);
    wr_reg(8'h44, 32'h20);
    irq_in[4] = 1'b0; wait_cyc(3); irq_in[4] = 1'b1; wait_cyc(6);
    check("R3 disabled edge", {24'b0, pend_col(4)}, 32'h0);
    irq_in[4] = 1'b0; wr_reg(8'h84 - 8'h04, 32'h10); wait_cyc(3);
  endtask

  task automatic t_rising;
    logic [31:0] v;
    wr_reg(8'h68, 32'h28);
    irq_in[40] = 1'b1; wait_cyc(3); irq_in[40] = 1'b0; wait_cyc(6);
    check("R5 rising latched", {31'b0, pend_at(0, 40)}, 32'h1);
    rd_reg(8'h84, v); check("R8 status bit8 of upper word", {31'b0, v[8]}, 32'h1);
    wr_reg(8'h84, 32'h0); wait_cyc(3);
    check("R8 zero write keeps", {31'b0, pend_at(0, 40)}, 32'h1);
    wr_reg(8'h84, 32'h100); wait_cyc(3);
    check("R8 w1c clears", {31'b0, pend_at(0, 40)}, 32'h0);
  endtask

  task automatic t_falling;
    wr_reg(8'h4A, 32'h48);
    irq_in[10] = 1'b1; wait_cyc(6);
    check("R6 rise ignored", {31'b0, pend_at(0, 10)}, 32'h0);
    irq_in[10] = 1'b0; wait_cyc(6);
    check("R6 fall latched", {31'b0, pend_at(0, 10)}, 32'h1);
    wr_reg(8'h80, 32'h400); wait_cyc(3);
  endtask

  task automatic t_both;
    wr_reg(8'h4B, 32'h68);
    irq_in[11] = 1'b1; wait_cyc(6);
    check("R7 rise latched", {31'b0, pend_at(0, 11)}, 32'h1);
    wr_reg(8'h80, 32'h800); wait_cyc(3);
    check("R7 cleared", {31'b0, pend_at(0, 11)}, 32'h0);
    irq_in[11] = 1'b0; wait_cyc(6);
    check("R7 fall latched", {31'b0, pend_at(0, 11)}, 32'h1);
  endtask

  task automatic t_route;
    irq_in[20] = 1'b1;
    for (int d = 0; d < 8; d++) begin
      wr_reg(8'h54, 32'h08 | d);
      wait_cyc(4);
      check($sformatf("R10 dest %0d", d), {24'b0, pend_col(20)}, 32'h1 << d);
    end
    irq_in[20] = 1'b0; wr_reg(8'h54, 32'h0);
  endtask

  task automatic t_clear_race;
    wr_reg(8'h5E, 32'h28);
    irq_in[30] = 1'b0; wait_cyc(4);
    irq_in[30] = 1'b1; wait_cyc(4); irq_in[30] = 1'b0; wait_cyc(4);
    check("R9 first edge", {31'b0, pend_at(0, 30)}, 32'h1);
    irq_in[30] = 1'b1;       // driven at a falling edge
    @(posedge clk);          // first synchronizer stage
    @(negedge clk);
    @(posedge clk);          // second stage, edge seen
    @(negedge clk);
    reg_addr = 8'h80; reg_wdata = 32'h4000_0000; reg_wr = 1'b1;
    @(negedge clk);          // event and clear share this edge
    reg_wr = 1'b0;
    wait_cyc(3);
    check("R9 edge beats clear", {31'b0, pend_at(0, 30)}, 32'h1);
    wr_reg(8'h80, 32'h4000_0000); wait_cyc(3);
    check("R9 later clear", {31'b0, pend_at(0, 30)}, 32'h0);
    irq_in[30] = 1'b0;
  endtask

  initial begin
    rst = 1'b1; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0; irq_in = '0;
    wait_cyc(4);
    rst = 1'b0;
    wait_cyc(1);
    t_reset();
    t_ctrl_rw();
    t_level();
    t_disable();
    t_rising();
    t_falling();
    t_both();
    t_route();
    t_clear_race();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule